// File: doc/BRIEF.md
# Host Bridge CPU Address Decoder

This block sits on the CPU side of a host-to-PCI bridge. Every access strobed on the 32-bit CPU bus is classified against a fixed address map. The map holds an I/O window, a direct configuration window, a one-byte interrupt-acknowledge location, a PCI memory window and a read-only boot ROM at the top of the address space. Any other address is unmapped. For each hit the block forms the downstream address, a region code and byte-lane enables, and issues a single-cycle request that the PCI cycle engine, the ROM or the interrupt controller consumes.

In the configuration window, a one-hot device-select field in the address is turned into a device number, and that number is packed above the register offset. The I/O window has two layouts. One is a flat 64 KiB layout. The other is a sparse layout that folds an 8 MiB window down to 16 bits. A mode pin chooses between them, and it is sampled afresh with every access. Accesses that hit nothing, or that a region cannot accept, raise a one-cycle error and return all ones on reads. Writes to the ROM are dropped without an error.

Top module: `hb_addr_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it falls, every output is zero.
- R2: For a strobe sampled at clock edge N, the request or the error appears from edge N for exactly one cycle, together with the translated address, byte enables, write flag and region code. Region codes: none=0, I/O=1, config=2, interrupt-ack=3, memory=4, ROM=5. A cycle with no strobe gives neither request nor error.
- R3: Addresses 0x8080_0000 to 0x80BF_FFFF select config. Offset bits 11 to 21 are scanned from low to high, and the device number is the position of the first set bit counted from bit 11, or 11 if none is set. The output address is device number × 0x800 plus offset bits 10:0.
- R4: Addresses 0x8000_0000 to 0x807F_FFFF select I/O. With the mode pin at 0, the output address is offset bits 15:0.
- R5: With the mode pin at 1, the I/O output address is offset bits 4:0 in bits 4:0 and offset bits 22:12 in bits 15:5.
- R6: The mode pin is taken from the same cycle as each strobe, so back-to-back accesses may use different layouts.
- R7: Address 0xBFFF_FFF0 is interrupt-acknowledge. It is forwarded only as a one-byte read, with output address 0. Any other size, and any write, gives an error.
- R8: Addresses 0xC000_0000 to 0xFFEF_FFFF select memory, and the output address is the CPU address minus 0xC000_0000.
- R9: Addresses 0xFFF0_0000 and above select the ROM, and the output address is the low 20 bits. A ROM write produces neither a request nor an error.
- R10: Size codes are 0=1 byte, 1=2 bytes and 2=4 bytes, and the data is little-endian. The 8-bit byte enable is the lane mask (0x1, 0x3, 0xF) shifted left by address bits 1:0. Bits 7:4 cover the next word, so an I/O access may cross a word boundary.
- R11: Size code 3 gives an error. So does a 2-byte access at an odd address, or a 4-byte access not on a 4-byte boundary, in any region other than I/O.
- R12: An access that hits no region gives an error and no request. The error read data is all ones for a read and zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Access strobe, one cycle per access |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_size_i | input | 2 | Access size code |
| io_mode_i | input | 1 | I/O layout: 0 flat, 1 sparse |
| dn_req_o | output | 1 | One-cycle downstream request |
| dn_region_o | output | 3 | Region code of the request |
| dn_addr_o | output | 32 | Translated downstream address |
| dn_be_o | output | 8 | Byte-lane enables over two words |
| dn_we_o | output | 1 | Write flag of the registered access |
| err_o | output | 1 | One-cycle error for a rejected access |
| err_rdata_o | output | 32 | Read data returned with an error |

## Verification
All results are due one register stage after the strobe. The bench drives each access on a falling edge, lets one rising edge capture it, and compares every output at the following falling edge. At that point it also drops the strobe, so the next falling edge shows whether the request and error really last a single cycle. In the back-to-back mode test, the second access is driven while the first one's result is being checked. This proves that the layout choice follows each strobe's own cycle.

// File: rtl/hb_dec_pkg.sv
package hb_dec_pkg;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_IO   = 3'd1,
        RG_CFG  = 3'd2,
        RG_IACK = 3'd3,
        RG_MEM  = 3'd4,
        RG_ROM  = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    // Registered downstream command
    typedef struct packed {
        logic        req;
        logic        err;
        logic        we;
        region_e     region;
        logic [31:0] addr;
        logic [7:0]  be;
    } dn_cmd_t;

    // Lane mask before the byte-offset shift
    function automatic logic [3:0] size_mask(input logic [1:0] sz);
        case (size_e'(sz))
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            SZ_WORD: size_mask = 4'b1111;
            default: size_mask = 4'b0000;
        endcase
    endfunction

    function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] lo);
        case (size_e'(sz))
            SZ_HALF: is_misaligned = lo[0];
            SZ_WORD: is_misaligned = (lo != 2'b00);
            default: is_misaligned = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hb_region_match.sv
module hb_region_match
    import hb_dec_pkg::*;
#(
    parameter logic [31:0] IO_BASE   = 32'h8000_0000,
    parameter int          IO_LOG2   = 23,
    parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
    parameter int          CFG_LOG2  = 22,
    parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
    parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
    parameter int          ROM_LOG2  = 20
) (
    input  logic [31:0] addr,
    output region_e     region
);
    localparam logic [31:0] ROM_BASE = ~((32'd1 << ROM_LOG2) - 32'd1);

    logic hit_io, hit_cfg, hit_iack, hit_mem, hit_rom;

    assign hit_io   = (addr >> IO_LOG2)  == (IO_BASE >> IO_LOG2);
    assign hit_cfg  = (addr >> CFG_LOG2) == (CFG_BASE >> CFG_LOG2);
    assign hit_iack = (addr == IACK_ADDR);
    assign hit_rom  = (addr >= ROM_BASE);
    assign hit_mem  = (addr >= MEM_BASE) && !hit_rom;

    // Fixed priority: the narrower windows win over the wider ones
    always_comb begin
        if (hit_rom)       region = RG_ROM;
        else if (hit_iack) region = RG_IACK;
        else if (hit_cfg)  region = RG_CFG;
        else if (hit_io)   region = RG_IO;
        else if (hit_mem)  region = RG_MEM;
        else               region = RG_NONE;
    end
endmodule

// File: rtl/hb_cfg_encode.sv
module hb_cfg_encode #(
    parameter int SCAN_N = 11,
    parameter int IDX_W  = $clog2(SCAN_N + 1)
) (
    input  logic [SCAN_N-1:0] sel,
    output logic [IDX_W-1:0]  idx
);
    // Priority chain from the top down: the lowest set bit wins,
    // and an empty field yields SCAN_N
    logic [IDX_W-1:0] stage [0:SCAN_N];

    assign stage[SCAN_N] = IDX_W'(SCAN_N);

    for (genvar g = SCAN_N - 1; g >= 0; g--) begin : g_scan
        assign stage[g] = sel[g] ? IDX_W'(g) : stage[g+1];
    end

    assign idx = stage[0];
endmodule

// File: rtl/hb_io_map.sv
module hb_io_map #(
    parameter int OFF_W  = 23,
    parameter int OUT_W  = 16,
    parameter int PASS_W = 5,
    parameter int HI_LO  = 12
) (
    input  logic             sparse,
    input  logic [OFF_W-1:0] off,
    output logic [OUT_W-1:0] xaddr
);
    localparam int HI_W = OFF_W - HI_LO;

    logic [OUT_W-1:0] flat_addr;
    logic [OUT_W-1:0] sparse_addr;

    assign flat_addr   = off[OUT_W-1:0];
    assign sparse_addr = OUT_W'({off[OFF_W-1:HI_LO], off[PASS_W-1:0]});

    if (HI_W + PASS_W > OUT_W) begin : g_bad_cfg
        initial $error("hb_io_map: sparse layout wider than output");
    end

    assign xaddr = sparse ? sparse_addr : flat_addr;
endmodule

// File: rtl/hb_lane_gen.sv
module hb_lane_gen
    import hb_dec_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] lo,
    output logic [7:0] be,
    output logic       misalign,
    output logic       bad_size
);
    assign be       = {4'b0000, size_mask(size)} << lo;
    assign misalign = is_misaligned(size, lo);
    assign bad_size = (size_e'(size) == SZ_BAD);
endmodule

// File: rtl/hb_addr_decoder.sv
module hb_addr_decoder
    import hb_dec_pkg::*;
#(
    parameter logic [31:0] IO_BASE    = 32'h8000_0000,
    parameter int          IO_LOG2    = 23,
    parameter int          IO_FLAT_W  = 16,
    parameter int          IO_PASS_W  = 5,
    parameter int          IO_HI_LO   = 12,
    parameter logic [31:0] CFG_BASE   = 32'h8080_0000,
    parameter int          CFG_LOG2   = 22,
    parameter int          CFG_SCAN_LO = 11,
    parameter logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0,
    parameter logic [31:0] MEM_BASE   = 32'hC000_0000,
    parameter int          ROM_LOG2   = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req_i,
    input  logic        cpu_we_i,
    input  logic [31:0] cpu_addr_i,
    input  logic [1:0]  cpu_size_i,
    input  logic        io_mode_i,
    output logic        dn_req_o,
    output logic [2:0]  dn_region_o,
    output logic [31:0] dn_addr_o,
    output logic [7:0]  dn_be_o,
    output logic        dn_we_o,
    output logic        err_o,
    output logic [31:0] err_rdata_o
);
    localparam int          CFG_SCAN_N = CFG_LOG2 - CFG_SCAN_LO;
    localparam int          CFG_IDX_W  = $clog2(CFG_SCAN_N + 1);
    localparam logic [31:0] ROM_MASK   = (32'd1 << ROM_LOG2) - 32'd1;

    region_e               region;
    logic [IO_FLAT_W-1:0]  io_xaddr;
    logic [CFG_IDX_W-1:0]  cfg_idx;
    logic [7:0]            be;
    logic                  misalign, bad_size;
    logic [31:0]           xaddr;
    logic                  reject, drop, fwd;
    dn_cmd_t               cmd_q;

    hb_region_match #(
        .IO_BASE  (IO_BASE),
        .IO_LOG2  (IO_LOG2),
        .CFG_BASE (CFG_BASE),
        .CFG_LOG2 (CFG_LOG2),
        .IACK_ADDR(IACK_ADDR),
        .MEM_BASE (MEM_BASE),
        .ROM_LOG2 (ROM_LOG2)
    ) u_match (
        .addr  (cpu_addr_i),
        .region(region)
    );

    hb_cfg_encode #(
        .SCAN_N(CFG_SCAN_N),
        .IDX_W (CFG_IDX_W)
    ) u_cfg (
        .sel(cpu_addr_i[CFG_SCAN_LO +: CFG_SCAN_N]),
        .idx(cfg_idx)
    );

    hb_io_map #(
        .OFF_W (IO_LOG2),
        .OUT_W (IO_FLAT_W),
        .PASS_W(IO_PASS_W),
        .HI_LO (IO_HI_LO)
    ) u_io (
        .sparse(io_mode_i),
        .off   (cpu_addr_i[IO_LOG2-1:0]),
        .xaddr (io_xaddr)
    );

    hb_lane_gen u_lane (
        .size    (cpu_size_i),
        .lo      (cpu_addr_i[1:0]),
        .be      (be),
        .misalign(misalign),
        .bad_size(bad_size)
    );

    // Per-region downstream address
    always_comb begin
        case (region)
            RG_IO:   xaddr = 32'(io_xaddr);
            RG_CFG:  xaddr = 32'({cfg_idx, cpu_addr_i[CFG_SCAN_LO-1:0]});
            RG_MEM:  xaddr = cpu_addr_i - MEM_BASE;
            RG_ROM:  xaddr = cpu_addr_i & ROM_MASK;
            default: xaddr = 32'd0;
        endcase
    end

    // Acceptance: errors first, then the silent ROM-write drop
    always_comb begin
        reject = 1'b0;
        if (bad_size || region == RG_NONE)
            reject = 1'b1;
        else if (region == RG_IACK && (cpu_we_i || size_e'(cpu_size_i) != SZ_BYTE))
            reject = 1'b1;
        else if (misalign && region != RG_IO)
            reject = 1'b1;
    end

    assign drop = !reject && region == RG_ROM && cpu_we_i;
    assign fwd  = !reject && !drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q.req <= cpu_req_i && fwd;
            cmd_q.err <= cpu_req_i && reject;
            if (cpu_req_i) begin
                cmd_q.we     <= cpu_we_i;
                cmd_q.region <= fwd ? region : RG_NONE;
                cmd_q.addr   <= fwd ? xaddr : 32'd0;
                cmd_q.be     <= fwd ? be : 8'd0;
            end
        end
    end

    assign dn_req_o    = cmd_q.req;
    assign dn_region_o = cmd_q.region;
    assign dn_addr_o   = cmd_q.addr;
    assign dn_be_o     = cmd_q.be;
    assign dn_we_o     = cmd_q.we;
    assign err_o       = cmd_q.err;
    assign err_rdata_o = {32{cmd_q.err && !cmd_q.we}};
endmodule

// File: rtl/hb_addr_decoder_chk.sv
module hb_addr_decoder_chk
    import hb_dec_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cpu_req_i,
    input logic        cpu_we_i,
    input logic [31:0] cpu_addr_i,
    input logic [1:0]  cpu_size_i,
    input logic        io_mode_i,
    input logic        dn_req_o,
    input logic [2:0]  dn_region_o,
    input logic [31:0] dn_addr_o,
    input logic [7:0]  dn_be_o,
    input logic        dn_we_o,
    input logic        err_o,
    input logic [31:0] err_rdata_o
);
    // R2: nothing comes out without a strobe one cycle earlier
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_req_i |=> !dn_req_o && !err_o);

    // R2: a forwarded request always carries a real region
    assert_region_valid_R2: assert property (@(posedge clk) disable iff (rst)
        dn_req_o |-> dn_region_o != RG_NONE && dn_region_o <= RG_ROM);

    // R12: request and error never coincide
    assert_req_err_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(dn_req_o && err_o));

    // R12: reads below the I/O window are unmapped and return all ones
    assert_unmapped_fill_R12: assert property (@(posedge clk) disable iff (rst)
        cpu_req_i && !cpu_we_i && !cpu_addr_i[31] |=> err_o && err_rdata_o == 32'hFFFF_FFFF);

    // R7: interrupt-acknowledge is a one-byte read
    assert_iack_byte_R7: assert property (@(posedge clk) disable iff (rst)
        dn_req_o && dn_region_o == RG_IACK |-> dn_be_o == 8'h01 && !dn_we_o);

    // R9: ROM never sees a write
    assert_rom_ro_R9: assert property (@(posedge clk) disable iff (rst)
        dn_req_o && dn_region_o == RG_ROM |-> !dn_we_o);

    // R3: config address fits device number plus 11-bit offset
    assert_cfg_width_R3: assert property (@(posedge clk) disable iff (rst)
        dn_req_o && dn_region_o == RG_CFG |-> dn_addr_o[31:15] == 17'd0);

    // R4: flat I/O layout stays inside 64 KiB
    assert_io_flat_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_req_i && !io_mode_i && cpu_addr_i[31:23] == 9'h100 && cpu_size_i != 2'd3
        |=> dn_req_o && dn_addr_o[31:16] == 16'd0);

    // R10: lane count matches a legal size
    assert_be_count_R10: assert property (@(posedge clk) disable iff (rst)
        dn_req_o |-> $countones(dn_be_o) == 1 || $countones(dn_be_o) == 2
                     || $countones(dn_be_o) == 4);
endmodule

bind hb_addr_decoder hb_addr_decoder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_req_i  (cpu_req_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_addr_i (cpu_addr_i),
    .cpu_size_i (cpu_size_i),
    .io_mode_i  (io_mode_i),
    .dn_req_o   (dn_req_o),
    .dn_region_o(dn_region_o),
    .dn_addr_o  (dn_addr_o),
    .dn_be_o    (dn_be_o),
    .dn_we_o    (dn_we_o),
    .err_o      (err_o),
    .err_rdata_o(err_rdata_o)
);

// File: tb/hb_addr_decoder_tb_top.sv
module hb_addr_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_i = 1'b0;
    logic        cpu_we_i = 1'b0;
    logic [31:0] cpu_addr_i = 32'd0;
    logic [1:0]  cpu_size_i = 2'd0;
    logic        io_mode_i = 1'b0;
    logic        dn_req_o;
    logic [2:0]  dn_region_o;
    logic [31:0] dn_addr_o;
    logic [7:0]  dn_be_o;
    logic        dn_we_o;
    logic        err_o;
    logic [31:0] err_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hb_addr_decoder dut_i (
        .clk(clk), .rst(rst),
        .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
        .cpu_size_i(cpu_size_i), .io_mode_i(io_mode_i),
        .dn_req_o(dn_req_o), .dn_region_o(dn_region_o), .dn_addr_o(dn_addr_o),
        .dn_be_o(dn_be_o), .dn_we_o(dn_we_o), .err_o(err_o), .err_rdata_o(err_rdata_o)
    );

    // Vector: tag[84:81] addr[80:49] size[48:47] we[46] mode[45]
    //         req[44] err[43] region[42:40] xaddr[39:8] be[7:0]
    localparam int NV = 23;
    localparam logic [84:0] VEC [NV] = '{
        {4'd4,  32'h8000_1234, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 32'h0000_1234, 8'h03}, // R4
        {4'd4,  32'h8045_ABCD, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 32'h0000_ABCD, 8'h02}, // R4
        {4'd5,  32'h8045_ABCD, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 32'h0000_8B4D, 8'h02}, // R5
        {4'd5,  32'h8012_3015, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 32'h0000_2475, 8'h02}, // R5
        {4'd10, 32'h807F_F01E, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 32'h0000_FFFE, 8'h3C}, // R10
        {4'd10, 32'h8000_0003, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 32'h0000_0003, 8'h18}, // R10
        {4'd3,  32'h8080_0810, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 32'h0000_0010, 8'h0F}, // R3
        {4'd3,  32'h8089_0004, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 32'h0000_2804, 8'h0F}, // R3
        {4'd3,  32'h8080_0004, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 32'h0000_5804, 8'h0F}, // R3
        {4'd3,  32'h80A0_0002, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 32'h0000_5002, 8'h0C}, // R3
        {4'd7,  32'hBFFF_FFF0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 32'h0000_0000, 8'h01}, // R7
        {4'd7,  32'hBFFF_FFF0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R7
        {4'd7,  32'hBFFF_FFF0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R7
        {4'd8,  32'hC123_4568, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 32'h0123_4568, 8'h0F}, // R8
        {4'd8,  32'hFFEF_FFFC, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 32'h3FEF_FFFC, 8'h0F}, // R8
        {4'd9,  32'hFFF0_0104, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 32'h0000_0104, 8'h0F}, // R9
        {4'd9,  32'hFFF8_0000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_0000, 8'h00}, // R9
        {4'd12, 32'h1000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R12
        {4'd12, 32'h80C0_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R12
        {4'd12, 32'hBFFF_FFF1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R12
        {4'd11, 32'hC000_0001, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R11
        {4'd11, 32'h8000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}, // R11
        {4'd11, 32'h8080_0802, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0000, 8'h00}  // R11
    };

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Drive on a falling edge; the registered result is compared one
    // falling edge later, when the strobe is also dropped
    task automatic drive(input logic [31:0] a, input logic [1:0] sz,
                         input logic we, input logic md);
        cpu_req_i  = 1'b1;
        cpu_addr_i = a;
        cpu_size_i = sz;
        cpu_we_i   = we;
        io_mode_i  = md;
    endtask

    task automatic expect_out(input string rq, input logic req, input logic err,
                              input logic [2:0] rg, input logic [31:0] xa,
                              input logic [7:0] be);
        chk(rq, "req", 64'(dn_req_o), 64'(req));
        chk(rq, "err", 64'(err_o), 64'(err));
        if (req) begin
            chk(rq, "region", 64'(dn_region_o), 64'(rg));
            chk(rq, "addr", 64'(dn_addr_o), 64'(xa));
            chk(rq, "be", 64'(dn_be_o), 64'(be));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        string rq;
        // R1: outputs zero in reset and just after it
        repeat (3) @(negedge clk);
        chk("R1", "in-reset outputs",
            64'({dn_req_o, err_o, dn_we_o, dn_region_o, dn_be_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "post-reset outputs",
            64'({dn_req_o, err_o, dn_we_o, dn_region_o, dn_be_o}), 64'd0);
        chk("R1", "post-reset addr/data", {dn_addr_o, err_rdata_o}, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][80:49], VEC[i][48:47], VEC[i][46], VEC[i][45]);
            @(negedge clk);
            cpu_req_i = 1'b0;
            rq = $sformatf("R%0d", VEC[i][84:81]);
            expect_out(rq, VEC[i][44], VEC[i][43], VEC[i][42:40], VEC[i][39:8], VEC[i][7:0]);
            if (VEC[i][44]) chk(rq, "we", 64'(dn_we_o), 64'(VEC[i][46]));
            @(negedge clk);
        end

        // R12: error read data is all ones for a read, zero for a write
        drive(32'h0000_0100, 2'd0, 1'b0, 1'b0);
        @(negedge clk); cpu_req_i = 1'b0;
        chk("R12", "read fill", 64'(err_rdata_o), 64'hFFFF_FFFF);
        @(negedge clk);
        drive(32'h0000_0100, 2'd0, 1'b1, 1'b0);
        @(negedge clk); cpu_req_i = 1'b0;
        chk("R12", "write fill", 64'(err_rdata_o), 64'd0);
        chk("R12", "write err", 64'(err_o), 64'd1);

        // R2: request lasts one cycle only
        @(negedge clk);
        drive(32'hC000_0000, 2'd2, 1'b0, 1'b0);
        @(negedge clk); cpu_req_i = 1'b0;
        chk("R2", "pulse high", 64'(dn_req_o), 64'd1);
        @(negedge clk);
        chk("R2", "pulse low", 64'({dn_req_o, err_o}), 64'd0);

        // R6: back-to-back accesses with the mode flipping each cycle
        drive(32'h8045_ABCD, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        drive(32'h8045_ABCD, 2'd0, 1'b0, 1'b0);
        expect_out("R6", 1'b1, 1'b0, 3'd1, 32'h0000_8B4D, 8'h02);
        @(negedge clk);
        drive(32'h8045_ABCD, 2'd0, 1'b0, 1'b1);
        expect_out("R6", 1'b1, 1'b0, 3'd1, 32'h0000_ABCD, 8'h02);
        @(negedge clk);
        cpu_req_i = 1'b0;
        expect_out("R6", 1'b1, 1'b0, 3'd1, 32'h0000_8B4D, 8'h02);
        @(negedge clk);

        // R9: a ROM write leaves both strobes low on the following cycle too
        drive(32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0);
        @(negedge clk); cpu_req_i = 1'b0;
        chk("R9", "rom write silent", 64'({dn_req_o, err_o}), 64'd0);
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule